// File: doc/BRIEF.md
# Multi-mode vector load address generator

This block turns one vector-load instruction word into the per-lane read addresses for a scratchpad, a lane enable vector and the number of the vector register that will receive the row. The opcode selects one of five addressing modes:

- plain strided;
- windowed inside a ring buffer;
- windowed with the ring offset advanced afterwards;
- per-lane indexed gather;
- indexed gather confined to a ring window.

Ring windows are described by a bank of 16 descriptors, each holding a base, a size and a current offset. The descriptors live outside the block and arrive on its inputs. When the advancing mode is used, the block sends back the updated offset for the selected descriptor.

The load carries no element type; typing is left to whichever instruction consumes the loaded register. The block registers all of its outputs, so every result appears one clock after the instruction is accepted. A lane-predicate bank, indexed by the mask field, decides which lanes issue a read.

Top module: `vld_addr_gen`

## Requirements
- R1: The mode is the 3-bit field at instruction bits 60..58. The codes are 0 plain, 1 ring, 2 ring with advance, 3 gather, 4 gather in ring. A legal code held on `in_valid` raises `out_valid` exactly one clock later.
- R2: In plain mode, lane L reads `(base_field << BASE_SHIFT) + offset_field + L*stride_field`, truncated to AW bits. The base field is bits 47..45, the offset field is bits 44..42 and the stride field is bits 41..38.
- R3: `dest_reg` carries bits 57..52 of the accepted instruction.
- R4: The mask field (bits 37..33) selects one LANES-bit predicate word from `pred_bank`. Bit L of that word is `lane_en[L]`.
- R5: In ring modes (1, 2, 4), the descriptor is chosen by bits 51..48. Lane L reads `wbase + ((woff + offset_field + L*stride_field) mod wsize)`. A window size of zero gives position 0.
- R6: Mode 2 raises `wb_valid` with `wb_sel` equal to the selector and `wb_off = (woff + LANES*stride_field) mod wsize`, or 0 when the size is zero. No other mode raises `wb_valid`.
- R7: In mode 3, lane L adds its own `lane_idx` value to the plain address, truncated to AW bits.
- R8: In mode 4, the lane's index value is added inside the window sum before the modulo.
- R9: Codes 5..7 raise `out_err` for one clock. In that clock `out_valid`, every `lane_en` bit and `wb_valid` are all low.
- R10: A cycle with `in_valid` low produces `out_valid`, `out_err`, `wb_valid` and `lane_en` all low on the next clock.
- R11: In modes 0 and 3, the ring selector and the descriptor contents have no effect on the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 64 | Vector-load instruction word |
| lane_idx | input | LANES*AW | Per-lane gather index values, lane 0 in the low bits |
| pred_bank | input | 32*LANES | Lane-predicate words, word 0 in the low bits |
| ring_base | input | 16*AW | Window base of each descriptor |
| ring_size | input | 16*AW | Window size of each descriptor |
| ring_off | input | 16*AW | Current offset of each descriptor |
| out_valid | output | 1 | Registered result is a legal load |
| out_err | output | 1 | Registered illegal-opcode flag |
| lane_en | output | LANES | Lanes that issue a read |
| lane_addr | output | LANES*AW | Per-lane scratchpad addresses |
| dest_reg | output | 6 | Destination vector register number |
| wb_valid | output | 1 | Descriptor offset write-back strobe |
| wb_sel | output | 4 | Descriptor being written back |
| wb_off | output | AW | New descriptor offset |

## Verification
The plain stride pattern is run with several base, offset and stride values. This separates the lane-times-stride term from the fixed base terms.

Ring windows are tried in three ways. One sum is chosen to cross the window end, which shows the wrap. A size-zero window exercises the degenerate position. A large window whose sum does not wrap exposes any stray modulo.

Gather index values are chosen near the top of the address range, so truncation in the plain gather can be told apart from the in-window gather. Two back-to-back advancing loads, with the returned offset fed back into the descriptor, show that the write-back carries a full vector's stride. The illegal codes, the idle cycles and a plain load with a non-zero selector probe the outputs that must stay quiet.

// File: rtl/vld_pkg.sv
package vld_pkg;

  localparam int OPC_LSB = 58;
  localparam int DST_LSB = 52;
  localparam int SEL_LSB = 48;
  localparam int BAS_LSB = 45;
  localparam int OFS_LSB = 42;
  localparam int STR_LSB = 38;
  localparam int MSK_LSB = 33;

  localparam int OPC_W = 3;
  localparam int DST_W = 6;
  localparam int SEL_W = 4;
  localparam int BAS_W = 3;
  localparam int OFS_W = 3;
  localparam int STR_W = 4;
  localparam int MSK_W = 5;

  localparam int NDESC = 2 ** SEL_W;
  localparam int NPRED = 2 ** MSK_W;

  localparam logic [OPC_W-1:0] OP_PLAIN       = 3'd0;
  localparam logic [OPC_W-1:0] OP_RING        = 3'd1;
  localparam logic [OPC_W-1:0] OP_RING_ADV    = 3'd2;
  localparam logic [OPC_W-1:0] OP_GATHER      = 3'd3;
  localparam logic [OPC_W-1:0] OP_GATHER_RING = 3'd4;

  typedef struct packed {
    logic             legal;
    logic             ring;
    logic             gather;
    logic             advance;
    logic [DST_W-1:0] dest;
    logic [SEL_W-1:0] sel;
    logic [BAS_W-1:0] base;
    logic [OFS_W-1:0] ofs;
    logic [STR_W-1:0] stride;
    logic [MSK_W-1:0] mask;
  } vld_dec_t;

endpackage

// File: rtl/vld_decode.sv
module vld_decode
  import vld_pkg::*;
(
  input  logic [63:0] instr,
  output vld_dec_t    dec
);
  logic [OPC_W-1:0] opc;
  logic             unused_bits;

  assign opc         = instr[OPC_LSB +: OPC_W];
  assign unused_bits = ^{instr[MSK_LSB-1:0], instr[63:OPC_LSB+OPC_W]};

  always_comb begin
    dec         = '0;
    dec.legal   = (opc <= OP_GATHER_RING);
    dec.ring    = (opc == OP_RING) || (opc == OP_RING_ADV) || (opc == OP_GATHER_RING);
    dec.gather  = (opc == OP_GATHER) || (opc == OP_GATHER_RING);
    dec.advance = (opc == OP_RING_ADV);
    dec.dest    = instr[DST_LSB +: DST_W];
    dec.sel     = instr[SEL_LSB +: SEL_W];
    dec.base    = instr[BAS_LSB +: BAS_W];
    dec.ofs     = instr[OFS_LSB +: OFS_W];
    dec.stride  = instr[STR_LSB +: STR_W];
    dec.mask    = instr[MSK_LSB +: MSK_W];
  end
endmodule

// File: rtl/vld_lane_addr.sv
module vld_lane_addr
  import vld_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int AW         = 16,
  parameter int BASE_SHIFT = 10
) (
  input  vld_dec_t            dec,
  input  logic [AW-1:0]       wbase,
  input  logic [AW-1:0]       wsize,
  input  logic [AW-1:0]       woff,
  input  logic [LANES*AW-1:0] lane_idx,
  output logic [LANES*AW-1:0] lane_addr
);
  localparam int SW = AW + 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SW-1:0] step;
    logic [SW-1:0] gidx;
    logic [SW-1:0] flat_sum;
    logic [SW-1:0] ring_sum;
    logic [SW-1:0] pos;

    always_comb begin
      step     = SW'(l) * SW'(dec.stride);
      gidx     = dec.gather ? SW'(lane_idx[l*AW +: AW]) : '0;
      flat_sum = (SW'(dec.base) << BASE_SHIFT) + SW'(dec.ofs) + step + gidx;
      ring_sum = SW'(woff) + SW'(dec.ofs) + step + gidx;
      pos      = (wsize == '0) ? '0 : (ring_sum % SW'(wsize));
      lane_addr[l*AW +: AW] = dec.ring ? (wbase + pos[AW-1:0]) : flat_sum[AW-1:0];
    end
  end
endmodule

// File: rtl/vld_ring_advance.sv
module vld_ring_advance
  import vld_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 16
) (
  input  logic [AW-1:0]    woff,
  input  logic [AW-1:0]    wsize,
  input  logic [STR_W-1:0] stride,
  output logic [AW-1:0]    new_off
);
  localparam int SW = AW + 8;
  logic [SW-1:0] sum;
  logic [SW-1:0] wrapped;

  always_comb begin
    sum     = SW'(woff) + SW'(LANES) * SW'(stride);
    wrapped = (wsize == '0) ? '0 : (sum % SW'(wsize));
    new_off = wrapped[AW-1:0];
  end
endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen
  import vld_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int AW         = 16,
  parameter int BASE_SHIFT = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [63:0]           instr,
  input  logic [LANES*AW-1:0]   lane_idx,
  input  logic [NPRED*LANES-1:0] pred_bank,
  input  logic [NDESC*AW-1:0]   ring_base,
  input  logic [NDESC*AW-1:0]   ring_size,
  input  logic [NDESC*AW-1:0]   ring_off,
  output logic                  out_valid,
  output logic                  out_err,
  output logic [LANES-1:0]      lane_en,
  output logic [LANES*AW-1:0]   lane_addr,
  output logic [DST_W-1:0]      dest_reg,
  output logic                  wb_valid,
  output logic [SEL_W-1:0]      wb_sel,
  output logic [AW-1:0]         wb_off
);
  vld_dec_t            dec;
  logic [AW-1:0]       wbase, wsize, woff, adv_off;
  logic [LANES-1:0]    pred_word;
  logic [LANES*AW-1:0] addr_c;
  logic                take;

  vld_decode i_dec (.instr(instr), .dec(dec));

  assign wbase     = ring_base[dec.sel*AW +: AW];
  assign wsize     = ring_size[dec.sel*AW +: AW];
  assign woff      = ring_off [dec.sel*AW +: AW];
  assign pred_word = pred_bank[dec.mask*LANES +: LANES];
  assign take      = in_valid && dec.legal;

  vld_lane_addr #(.LANES(LANES), .AW(AW), .BASE_SHIFT(BASE_SHIFT)) i_lanes (
    .dec(dec), .wbase(wbase), .wsize(wsize), .woff(woff),
    .lane_idx(lane_idx), .lane_addr(addr_c)
  );

  vld_ring_advance #(.LANES(LANES), .AW(AW)) i_adv (
    .woff(woff), .wsize(wsize), .stride(dec.stride), .new_off(adv_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      lane_en   <= '0;
      lane_addr <= '0;
      dest_reg  <= '0;
      wb_valid  <= 1'b0;
      wb_sel    <= '0;
      wb_off    <= '0;
    end else begin
      out_valid <= take;
      out_err   <= in_valid && !dec.legal;
      lane_en   <= take ? pred_word : '0;
      lane_addr <= addr_c;
      dest_reg  <= dec.dest;
      wb_valid  <= take && dec.advance;
      wb_sel    <= dec.sel;
      wb_off    <= adv_off;
    end
  end

  // R9: an illegal opcode must leave no read and no descriptor update behind
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (lane_en == '0) && !wb_valid && !out_valid);

  // R10: enables only accompany a valid result
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (lane_en == '0));

  // R1: any result follows an accepted instruction one clock earlier
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_err) |-> $past(in_valid));

  // R6: a write-back belongs to a legal load
  p_wb_legal_r6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> out_valid);

  // R6: the returned offset stays inside the window it was wrapped at
  p_wb_window_r6: assert property (@(posedge clk) disable iff (rst)
    (take && dec.advance && wsize != '0) |=> (wb_off < $past(wsize)));
endmodule

// File: tb/test_vld_addr_gen.sv
module test_vld_addr_gen;
  localparam int LANES = 8;
  localparam int AW    = 16;
  localparam int BSH   = 10;

  logic                  clk = 1'b0;
  logic                  rst;
  logic                  in_valid;
  logic [63:0]           instr;
  logic [LANES*AW-1:0]   lane_idx;
  logic [32*LANES-1:0]   pred_bank;
  logic [16*AW-1:0]      ring_base, ring_size, ring_off;
  logic                  out_valid, out_err, wb_valid;
  logic [LANES-1:0]      lane_en;
  logic [LANES*AW-1:0]   lane_addr;
  logic [5:0]            dest_reg;
  logic [3:0]            wb_sel;
  logic [AW-1:0]         wb_off;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected values of the next registered result
  bit e_valid, e_err, e_wb;
  int e_en, e_dest, e_sel, e_woff;
  int e_addr[LANES];
  string a_tag;

  always #2.5 clk = ~clk;

  vld_addr_gen #(.LANES(LANES), .AW(AW), .BASE_SHIFT(BSH)) i_vld_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .lane_idx(lane_idx), .pred_bank(pred_bank), .ring_base(ring_base),
    .ring_size(ring_size), .ring_off(ring_off), .out_valid(out_valid),
    .out_err(out_err), .lane_en(lane_en), .lane_addr(lane_addr),
    .dest_reg(dest_reg), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_off(wb_off)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rd(logic [16*AW-1:0] v, int i);
    return int'(v[i*AW +: AW]);
  endfunction

  task automatic set_desc(int i, int b, int s, int o);
    ring_base[i*AW +: AW] = AW'(b);
    ring_size[i*AW +: AW] = AW'(s);
    ring_off [i*AW +: AW] = AW'(o);
  endtask

  task automatic compare();
    @(negedge clk);
    chk(e_err ? "R9 valid" : (e_valid ? "R1 valid" : "R10 valid"), out_valid, e_valid);
    chk(e_err ? "R9 err" : "R10 err", out_err, e_err);
    chk("R4 lane_en", lane_en, e_en);
    chk("R6 wb_valid", wb_valid, e_wb);
    if (e_valid) begin
      chk("R3 dest", dest_reg, e_dest);
      for (int l = 0; l < LANES; l++)
        chk(a_tag, int'(lane_addr[l*AW +: AW]), e_addr[l]);
    end
    if (e_wb) begin
      chk("R6 wb_sel", wb_sel, e_sel);
      chk("R6 wb_off", wb_off, e_woff);
    end
  endtask

  task automatic issue(int op, int dst, int sel, int bas, int ofs, int str, int msk, string tag);
    bit ring, gat;
    int wb, ws, wo, gi, s;
    instr = 64'h0;
    instr[26:0]  = 27'h5A5A5A5;
    instr[60:58] = 3'(op);
    instr[57:52] = 6'(dst);
    instr[51:48] = 4'(sel);
    instr[47:45] = 3'(bas);
    instr[44:42] = 3'(ofs);
    instr[41:38] = 4'(str);
    instr[37:33] = 5'(msk);
    in_valid = 1'b1;
    ring = (op == 1) || (op == 2) || (op == 4);
    gat  = (op == 3) || (op == 4);
    wb = rd(ring_base, sel); ws = rd(ring_size, sel); wo = rd(ring_off, sel);
    e_valid = (op <= 4);
    e_err   = !e_valid;
    e_en    = e_valid ? int'(pred_bank[msk*LANES +: LANES]) : 0;
    e_dest  = dst;
    e_wb    = (op == 2);
    e_sel   = sel;
    e_woff  = (ws == 0) ? 0 : (wo + LANES * str) % ws;
    a_tag   = tag;
    for (int l = 0; l < LANES; l++) begin
      gi = gat ? int'(lane_idx[l*AW +: AW]) : 0;
      if (ring) begin
        s = wo + ofs + l * str + gi;
        e_addr[l] = (wb + ((ws == 0) ? 0 : s % ws)) & 'hFFFF;
      end else begin
        e_addr[l] = ((bas << BSH) + ofs + l * str + gi) & 'hFFFF;
      end
    end
    compare();
  endtask

  task automatic idle();
    in_valid = 1'b0;
    e_valid = 0; e_err = 0; e_en = 0; e_wb = 0;
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ivals[LANES] = '{3, 1000, 'hFFF0, 7, 0, 50, 2, 'hFFFF};
    rst = 1'b1; in_valid = 1'b0; instr = '0;
    lane_idx = '0; pred_bank = '0; ring_base = '0; ring_size = '0; ring_off = '0;
    for (int l = 0; l < LANES; l++) lane_idx[l*AW +: AW] = AW'(ivals[l]);
    pred_bank[0*LANES +: LANES]  = 8'hFF;
    pred_bank[7*LANES +: LANES]  = 8'hA5;
    pred_bank[12*LANES +: LANES] = 8'h3C;
    pred_bank[31*LANES +: LANES] = 8'h00;
    set_desc(3, 'h4000, 20, 15);
    set_desc(5, 'h1200, 0, 7);
    set_desc(9, 'h8000, 100, 90);
    set_desc(11, 'h2000, 1000, 10);
    repeat (3) @(negedge clk);
    // reset state
    chk("R10 reset valid", out_valid, 0);
    chk("R10 reset err", out_err, 0);
    chk("R10 reset wb", wb_valid, 0);
    chk("R10 reset en", lane_en, 0);
    rst = 1'b0;

    // plain strided, several patterns
    issue(0, 17, 0, 0, 0, 1, 0,  "R2 plain");
    issue(0, 63, 0, 7, 5, 15, 7, "R2 plain");
    issue(0, 2, 0, 3, 2, 0, 12,  "R2 plain");
    issue(0, 40, 0, 5, 7, 9, 31, "R4 plain masked");
    // selector ignored in plain and gather modes
    issue(0, 8, 9, 2, 1, 3, 0,   "R11 plain sel");
    issue(3, 9, 3, 2, 1, 3, 0,   "R11 gather sel");
    // ring window with wrap, size zero, no-wrap
    issue(1, 1, 3, 6, 4, 3, 0,   "R5 ring wrap");
    issue(1, 4, 5, 0, 3, 5, 7,   "R5 ring size0");
    issue(1, 6, 11, 0, 1, 2, 12, "R5 ring nowrap");
    // post-update streaming, feeding offset back
    issue(2, 10, 9, 0, 0, 4, 0,  "R5 ring adv");
    set_desc(9, 'h8000, 100, wb_off);
    issue(2, 11, 9, 0, 0, 4, 0,  "R6 ring adv second");
    issue(2, 12, 5, 0, 0, 7, 0,  "R6 ring adv size0");
    // gathers
    issue(3, 20, 0, 1, 2, 3, 0,  "R7 gather");
    issue(3, 21, 0, 7, 7, 15, 7, "R7 gather");
    issue(4, 22, 9, 0, 1, 1, 0,  "R8 gather ring");
    issue(4, 23, 3, 0, 0, 2, 12, "R8 gather ring");
    // illegal opcodes
    issue(5, 1, 9, 1, 1, 1, 0,   "R9 illegal");
    issue(6, 1, 9, 1, 1, 1, 0,   "R9 illegal");
    issue(7, 1, 9, 1, 1, 1, 0,   "R9 illegal");
    idle();
    issue(2, 30, 3, 0, 0, 1, 0,  "R5 ring adv");
    idle();
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule